// File: doc/BRIEF.md
# Increment/Decrement and Shift Flag Unit

This block is one execution slice of a small 8-bit processor core. It takes an operand that the surrounding datapath has already fetched, and performs one of ten register-style operations on it. The operations are byte or word increment, byte or word decrement, and logical-left, logical-right or arithmetic-right shifts of a byte or a word by a variable count. It also takes the incoming zero, auxiliary-carry and carry flags and produces their new values. Each class of operation has its own rule for which flags it may change.

The caller presents an opcode, a 16-bit operand, a 4-bit shift count and the current flags, and raises a request for one cycle. The result and the new flags are registered on that clock edge, and a done strobe is high for exactly the following cycle. When no request is present the outputs hold their last values. Instruction decode, address generation and memory access belong to other blocks.

Top module: `sfu_top`

## Requirements
- R1: Opcode 0 (byte increment) returns (operand[7:0] + 1) mod 256 in result[7:0], with result[15:8] = 0. Z is set exactly when that byte is zero. AC is the carry out of bit 3. CY is passed through unchanged.
- R2: Opcode 1 (byte decrement) returns (operand[7:0] - 1) mod 256 in result[7:0], with result[15:8] = 0. Z is set exactly when that byte is zero. AC is the borrow out of bit 3. CY is passed through unchanged.
- R3: Opcodes 2 (word increment) and 3 (word decrement) return the 16-bit operand plus or minus 1, mod 65536. Z, AC and CY are all passed through unchanged.
- R4: Opcodes 4 (byte) and 5 (word) shift right logically by the effective count, filling the top bit with zeros. CY becomes the last bit shifted out, which is operand bit (count-1).
- R5: Opcodes 6 (byte) and 7 (word) shift left by the effective count, filling bit 0 with zeros. CY becomes operand bit (width - count).
- R6: Opcodes 8 (byte) and 9 (word) shift right arithmetically, replicating the top bit. CY becomes operand bit (count-1).
- R7: The effective count is cnt[2:0] for byte shifts and cnt[3:0] for word shifts. An effective count of 0 returns the operand unchanged and leaves CY unchanged.
- R8: Every shift leaves Z and AC unchanged. Byte shifts read only operand[7:0] and return result[15:8] = 0.
- R9: The result, the flags and done are registered on the edge where request is sampled high. Done is high for exactly the one cycle after each request.
- R10: While request is low, the result and the flags hold their values and done stays low.
- R11: During reset the result and all flags are zero and done is low.
- R12: Opcodes 10 to 15 return the operand unchanged and pass all three flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Operation request, one cycle |
| op_i | input | 4 | Opcode (encoding in R1 to R6, R12) |
| opnd_i | input | 16 | Operand (byte operations use bits 7:0) |
| cnt_i | input | 4 | Shift count |
| z_i | input | 1 | Current zero flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| cy_i | input | 1 | Current carry flag |
| res_o | output | 16 | Registered result |
| z_o | output | 1 | Registered new zero flag |
| ac_o | output | 1 | Registered new auxiliary-carry flag |
| cy_o | output | 1 | Registered new carry flag |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
On every cycle the assertions enforce the flag-preservation rules: word steps keep all flags, byte steps keep CY, and shifts keep Z and AC. They also enforce the clear upper byte on byte operations, the one-cycle done strobe that follows each request, and the holding of the outputs while idle. The actual arithmetic is shown only by the bench's scenarios. These cover the wrap at 0xFF, 0x00 and 0xFFFF, the nibble carry and borrow, the bit that lands in CY for each shift kind and width, counts that reduce to zero or wrap modulo the width, and undefined opcodes.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [3:0] {
    OP_INC8  = 4'd0,
    OP_DEC8  = 4'd1,
    OP_INC16 = 4'd2,
    OP_DEC16 = 4'd3,
    OP_SHR8  = 4'd4,
    OP_SHR16 = 4'd5,
    OP_SHL8  = 4'd6,
    OP_SHL16 = 4'd7,
    OP_SAR8  = 4'd8,
    OP_SAR16 = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SHK_LEFT = 2'd0,
    SHK_RLOG = 2'd1,
    SHK_RARI = 2'd2
  } shk_e;

  function automatic logic is_byte_step(op_e op);
    return (op == OP_INC8) || (op == OP_DEC8);
  endfunction

  function automatic logic is_word_step(op_e op);
    return (op == OP_INC16) || (op == OP_DEC16);
  endfunction

  function automatic logic is_shift(op_e op);
    return (op == OP_SHR8) || (op == OP_SHR16) || (op == OP_SHL8) ||
           (op == OP_SHL16) || (op == OP_SAR8) || (op == OP_SAR16);
  endfunction

  function automatic logic is_byte_shift(op_e op);
    return (op == OP_SHR8) || (op == OP_SHL8) || (op == OP_SAR8);
  endfunction

endpackage

// File: rtl/sfu_incdec.sv
// Step-by-one adder. The nibble carry or borrow is read as bit 4 of
// operand XOR result, which is valid for +1 and for -1 alike.
module sfu_incdec #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic         dec_i,
  output logic [W-1:0] y_o,
  output logic         nib_o
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (dec_i) y_o = x_i - ONE;
    else       y_o = x_i + ONE;
    nib_o = x_i[4] ^ y_o[4];
  end

  initial begin
    assert (W >= 5) else $error("sfu_incdec needs W >= 5");
  end

endmodule

// File: rtl/sfu_shifter.sv
// Variable shifter that also returns the last bit shifted out.
// With amt = 0 the carry input comes back unchanged.
module sfu_shifter
  import sfu_pkg::*;
#(
  parameter int W     = 8,
  localparam int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     x_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shk_e             kind_i,
  input  logic             cy_i,
  output logic [W-1:0]     y_o,
  output logic             cy_o
);

  logic [2*W:0] rext;
  logic [W:0]   lext;
  logic [W-1:0] fill;

  always_comb begin
    fill = (kind_i == SHK_RARI) ? {W{x_i[W-1]}} : '0;
    rext = {fill, x_i, cy_i} >> amt_i;
    lext = {cy_i, x_i} << amt_i;
    if (kind_i == SHK_LEFT) begin
      y_o  = lext[W-1:0];
      cy_o = lext[W];
    end else begin
      y_o  = rext[W:1];
      cy_o = rext[0];
    end
  end

endmodule

// File: rtl/sfu_top.sv
module sfu_top
  import sfu_pkg::*;
#(
  parameter int  WORD_W = 16,
  parameter int  BYTE_W = 8,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [3:0]        op_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              z_i,
  input  logic              ac_i,
  input  logic              cy_i,
  output logic [WORD_W-1:0] res_o,
  output logic              z_o,
  output logic              ac_o,
  output logic              cy_o,
  output logic              done_o
);

  localparam int BAMT_W = $clog2(BYTE_W);
  localparam int PAD_W  = WORD_W - BYTE_W;

  // reset: asynchronous assert, two-flop synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  op_e op;
  assign op = op_e'(op_i);

  // increment / decrement path
  logic [WORD_W-1:0] step_x, step_y;
  logic              step_dec, step_nib;

  always_comb begin
    step_dec = (op == OP_DEC8) || (op == OP_DEC16);
    step_x   = is_byte_step(op) ? {{PAD_W{1'b0}}, opnd_i[BYTE_W-1:0]} : opnd_i;
  end

  sfu_incdec #(.W(WORD_W)) u_step (
    .x_i   (step_x),
    .dec_i (step_dec),
    .y_o   (step_y),
    .nib_o (step_nib)
  );

  // shift paths, one per width
  shk_e kind;
  always_comb begin
    case (op)
      OP_SHL8, OP_SHL16: kind = SHK_LEFT;
      OP_SAR8, OP_SAR16: kind = SHK_RARI;
      default:           kind = SHK_RLOG;
    endcase
  end

  logic [BYTE_W-1:0] sh_b_y;
  logic [WORD_W-1:0] sh_w_y;
  logic              sh_b_cy, sh_w_cy;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sh
      if (g == 0) begin : g_byte
        sfu_shifter #(.W(BYTE_W)) u_sh (
          .x_i    (opnd_i[BYTE_W-1:0]),
          .amt_i  (cnt_i[BAMT_W-1:0]),
          .kind_i (kind),
          .cy_i   (cy_i),
          .y_o    (sh_b_y),
          .cy_o   (sh_b_cy)
        );
      end else begin : g_word
        sfu_shifter #(.W(WORD_W)) u_sh (
          .x_i    (opnd_i),
          .amt_i  (cnt_i),
          .kind_i (kind),
          .cy_i   (cy_i),
          .y_o    (sh_w_y),
          .cy_o   (sh_w_cy)
        );
      end
    end
  endgenerate

  // next-state selection
  logic [WORD_W-1:0] nxt_res;
  logic              nxt_z, nxt_ac, nxt_cy;

  always_comb begin
    nxt_res = opnd_i;
    nxt_z   = z_i;
    nxt_ac  = ac_i;
    nxt_cy  = cy_i;
    case (op)
      OP_INC8, OP_DEC8: begin
        nxt_res = {{PAD_W{1'b0}}, step_y[BYTE_W-1:0]};
        nxt_z   = (step_y[BYTE_W-1:0] == '0);
        nxt_ac  = step_nib;
      end
      OP_INC16, OP_DEC16: begin
        nxt_res = step_y;
      end
      OP_SHR8, OP_SHL8, OP_SAR8: begin
        nxt_res = {{PAD_W{1'b0}}, sh_b_y};
        nxt_cy  = sh_b_cy;
      end
      OP_SHR16, OP_SHL16, OP_SAR16: begin
        nxt_res = sh_w_y;
        nxt_cy  = sh_w_cy;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_o  <= '0;
      z_o    <= 1'b0;
      ac_o   <= 1'b0;
      cy_o   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        res_o <= nxt_res;
        z_o   <= nxt_z;
        ac_o  <= nxt_ac;
        cy_o  <= nxt_cy;
      end
    end
  end

  // assertions
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> done_o); // R9
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !done_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> ($stable(res_o) && $stable(z_o) && $stable(ac_o) && $stable(cy_o))); // R10
  AST_WORD_STEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && is_word_step(op)) |=>
      (z_o == $past(z_i) && ac_o == $past(ac_i) && cy_o == $past(cy_i))); // R3
  AST_BYTE_STEP_CY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && is_byte_step(op)) |=> (cy_o == $past(cy_i))); // R1
  AST_SHIFT_KEEPS_ZAC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && is_shift(op)) |=> (z_o == $past(z_i) && ac_o == $past(ac_i))); // R8
  AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && (is_byte_step(op) || is_byte_shift(op))) |=> (res_o[WORD_W-1:BYTE_W] == '0)); // R8
  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && op_i > 4'd9) |=> (res_o == $past(opnd_i) && cy_o == $past(cy_i))); // R12

endmodule

// File: tb/tb_sfu_top.sv
module tb_sfu_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [3:0]  op_i;
  logic [15:0] opnd_i;
  logic [3:0]  cnt_i;
  logic        z_i, ac_i, cy_i;
  logic [15:0] res_o;
  logic        z_o, ac_o, cy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sfu_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .opnd_i(opnd_i),
    .cnt_i(cnt_i), .z_i(z_i), .ac_i(ac_i), .cy_i(cy_i), .res_o(res_o),
    .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o), .done_o(done_o)
  );

  // {op, operand, cnt, {z,ac,cy} in, result, {z,ac,cy} out}
  localparam int NV = 18;
  localparam logic [45:0] VEC [NV] = '{
    {4'd0, 16'h120F, 4'd0, 3'b001, 16'h0010, 3'b011}, // R1 nibble carry
    {4'd0, 16'h00FF, 4'd0, 3'b000, 16'h0000, 3'b110}, // R1 wrap to zero
    {4'd1, 16'h0010, 4'd0, 3'b101, 16'h000F, 3'b011}, // R2 nibble borrow
    {4'd1, 16'h0001, 4'd0, 3'b010, 16'h0000, 3'b100}, // R2 zero
    {4'd1, 16'h0000, 4'd0, 3'b101, 16'h00FF, 3'b011}, // R2 wrap
    {4'd2, 16'hFFFF, 4'd0, 3'b101, 16'h0000, 3'b101}, // R3 wrap
    {4'd3, 16'h0000, 4'd0, 3'b010, 16'hFFFF, 3'b010}, // R3 wrap
    {4'd4, 16'h00B5, 4'd3, 3'b110, 16'h0016, 3'b111}, // R4 byte
    {4'd5, 16'h8001, 4'd15,3'b001, 16'h0001, 3'b000}, // R4 word max
    {4'd6, 16'h0081, 4'd1, 3'b010, 16'h0002, 3'b011}, // R5 byte
    {4'd7, 16'h4001, 4'd2, 3'b100, 16'h0004, 3'b101}, // R5 word
    {4'd8, 16'h0090, 4'd4, 3'b001, 16'h00F9, 3'b000}, // R6 byte
    {4'd9, 16'h8004, 4'd3, 3'b000, 16'hF000, 3'b001}, // R6 word
    {4'd4, 16'h00A5, 4'd8, 3'b011, 16'h00A5, 3'b011}, // R7 byte count 8 -> 0
    {4'd6, 16'h0040, 4'd9, 3'b111, 16'h0080, 3'b110}, // R7 byte count 9 -> 1
    {4'd5, 16'h1234, 4'd0, 3'b000, 16'h1234, 3'b000}, // R7 word count 0
    {4'd15,16'hBEEF, 4'd0, 3'b101, 16'hBEEF, 3'b101}, // R12 undefined
    {4'd4, 16'hFF02, 4'd1, 3'b001, 16'h0001, 3'b000}  // R8 upper byte ignored
  };
  localparam int TAG [NV] = '{1,1,2,2,2,3,3,4,4,5,5,6,6,7,7,7,12,8};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // drive one request at a falling edge; sample at the next falling edge
  task automatic issue(input logic [3:0] op, input logic [15:0] d, input logic [3:0] c,
                       input logic [2:0] f);
    @(negedge clk);
    op_i = op; opnd_i = d; cnt_i = c; {z_i, ac_i, cy_i} = f; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; op_i = '0; opnd_i = '0; cnt_i = '0;
    z_i = 1'b1; ac_i = 1'b1; cy_i = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 res", res_o, 16'h0);
    chk("R11 flags", {z_o, ac_o, cy_o}, 3'b000);
    chk("R11 done", done_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle after release", {res_o, z_o, ac_o, cy_o, done_o}, 20'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      string tag;
      v = VEC[i];
      issue(v[45:42], v[41:26], v[25:22], v[21:19]);
      tag = $sformatf("R%0d vec%0d", TAG[i], i);
      chk({tag, " res"}, res_o, v[18:3]);
      chk({tag, " flags"}, {z_o, ac_o, cy_o}, v[2:0]);
      chk({"R9 done ", tag}, done_o, 1'b1);
    end

    // R9 outputs do not change before the capturing edge; done lasts one cycle
    @(negedge clk);
    chk("R9 done single cycle", done_o, 1'b0);
    op_i = 4'd2; opnd_i = 16'h0041; cnt_i = 4'd0; {z_i, ac_i, cy_i} = 3'b010; req_i = 1'b1;
    #1;
    chk("R9 before edge", res_o, 16'h0001);
    @(negedge clk);
    req_i = 1'b0;
    chk("R9 after edge", res_o, 16'h0042);
    chk("R9 done", done_o, 1'b1);

    // R10 inputs change without request: nothing moves
    op_i = 4'd0; opnd_i = 16'h00FF; {z_i, ac_i, cy_i} = 3'b101;
    repeat (3) @(negedge clk);
    chk("R10 res held", res_o, 16'h0042);
    chk("R10 flags held", {z_o, ac_o, cy_o}, 3'b010);
    chk("R10 no done", done_o, 1'b0);

    // back-to-back requests, R9
    issue(4'd0, 16'h000E, 4'd0, 3'b001);
    chk("R1 b2b first", {res_o, z_o, ac_o, cy_o}, {16'h000F, 3'b001});
    @(negedge clk);
    op_i = 4'd7; opnd_i = 16'h8000; cnt_i = 4'd1; {z_i, ac_i, cy_i} = 3'b000; req_i = 1'b1;
    @(negedge clk);
    op_i = 4'd8; opnd_i = 16'h0001; cnt_i = 4'd1; {z_i, ac_i, cy_i} = 3'b110;
    chk("R5 b2b shl16", {res_o, cy_o}, {16'h0000, 1'b1});
    chk("R9 b2b done", done_o, 1'b1);
    @(negedge clk);
    req_i = 1'b0;
    chk("R6 b2b sar8", {res_o, z_o, ac_o, cy_o}, {16'h0000, 3'b111});
    chk("R9 b2b done held", done_o, 1'b1);

    // R11 reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk("R11 async clear", {res_o, z_o, ac_o, cy_o, done_o}, 20'h0);
    summary();
  end

endmodule